// File: doc/BRIEF.md
# Sample-Rate Speed-Mode Detector

The block works out the speed mode of an incoming audio stream without help from software. It runs on the master clock and measures how many master-clock cycles lie between two rising edges of word-select. The word-select input is synchronized into the master-clock domain first. Each measurement is matched, with a small tolerance, against seven legal ratios: 128, 192, 256, 384, 512, 768 and 1024.

Several of these ratios belong to more than one mode. To tell them apart, the block takes the master-clock frequency from a programmable input and works out the implied sample rate. It then checks that rate against the band of each mode:

| Mode | Mode code | Sample-rate band | Legal ratios |
|------|-----------|------------------|--------------|
| Single speed | 2'b00 | 30 to 54 kHz | 256 to 1024 |
| Double speed | 2'b01 | 84 to 108 kHz | 128 to 512 |
| Quad speed | 2'b10 | 170 to 216 kHz | 128 to 256 |

The outputs are:
- the mode code and the measured ratio code;
- a lock flag, set after three agreeing measurements;
- an unsupported flag, set for any measurement that fits no mode.

A de-emphasis request reaches the de-emphasis output only while the block is locked in single-speed mode.

Top module: `srate_mode_detect`

## Requirements
- R1: While rst_ni is low, mode_o is 2'b00, ratio_o is 0, and locked_o, unsup_o and deemph_o are all 0.
- R2: A measurement is the number of clk_i cycles between two successive rising edges of ws_i. It takes effect 3 clk_i edges after ws_i rises. ratio_o then shows its code: 1=128, 2=192, 3=256, 4=384, 5=512, 6=768, 7=1024 when the measurement is within ±2 of that ratio, and 0 when it is within ±2 of none.
- R3: If the ratio is 256, 384, 512, 768 or 1024 and mclk_khz_i/ratio lies in 30..54 kHz (bounds inclusive), mode_o becomes 2'b00 (single speed).
- R4: If the ratio is 128, 192, 256, 384 or 512 and the implied rate lies in 84..108 kHz, mode_o becomes 2'b01 (double speed).
- R5: If the ratio is 128, 192 or 256 and the implied rate lies in 170..216 kHz, mode_o becomes 2'b10 (quad speed).
- R6: A ratio shared by several modes is resolved by the implied rate alone. For example, ratio 256 gives single speed at 12288 kHz and double speed at 24576 kHz.
- R7: A measurement that matches no mode (ratio code 0, or implied rate outside every band) sets unsup_o and clears locked_o, and mode_o keeps its previous value. A supported measurement clears unsup_o.
- R8: locked_o rises after three consecutive supported measurements that carry the same ratio code.
- R9: Measurements within ±2 counts of the locked ratio keep the lock. A single measurement that deviates by more than 2 counts drops it.
- R10: If no rising edge of ws_i arrives within 2047 clk_i cycles, locked_o is cleared.
- R11: deemph_o equals deemph_req_i while locked_o is 1 and mode_o is 2'b00, and is 0 otherwise.
- R12: After reset, or after the timeout of R10, the first rising edge of ws_i produces no measurement; ratio_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ws_i | input | 1 | Word-select, asynchronous to clk_i |
| mclk_khz_i | input | 16 | Configured master-clock frequency in kHz |
| deemph_req_i | input | 1 | De-emphasis request |
| mode_o | output | 2 | Speed mode: 00 single, 01 double, 10 quad |
| ratio_o | output | 3 | Code of the last measured ratio |
| locked_o | output | 1 | Ratio stable for three periods |
| unsup_o | output | 1 | Last measurement fits no mode |
| deemph_o | output | 1 | Gated de-emphasis enable |

## Verification
Every registered result (mode_o, ratio_o, locked_o, unsup_o) follows a rising edge of ws_i by exactly three clk_i edges: two synchronizer flops, then the result register. The timeout of R10 lands on the 2047th edge with no rise. The bench's reference model takes ws_i as it is sampled at each edge and delays it by the same three edges before a measurement is counted. Outputs are compared two nanoseconds after every rising edge, so no comparison races the update. deemph_o is combinational from the request and the registered state, so its explicit checks follow a request change on the next falling edge.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int NUM_RATIOS = 7;
  localparam int RCODE_W    = 3;

  localparam logic [1:0] MODE_SINGLE = 2'b00;
  localparam logic [1:0] MODE_DOUBLE = 2'b01;
  localparam logic [1:0] MODE_QUAD   = 2'b10;

  // code 1..7 -> 128,192,256,384,512,768,1024
  function automatic int unsigned ratio_of(int unsigned code);
    int unsigned base;
    if (code == 0) return 0;
    base = 32'd128 << ((code - 1) / 2);
    if (code % 2 == 0) return base + base / 2;
    return base;
  endfunction
endpackage

// File: rtl/sr_ws_sync.sv
module sr_ws_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ws_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ws_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/sr_period_cnt.sv
module sr_period_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] period_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign meas_vld_o = rise_i & armed_q;
  assign period_o   = cnt_q + 1'b1;
  assign timeout_o  = ~rise_i & (cnt_q == CNT_MAX - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (timeout_o) armed_q <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sr_classify.sv
module sr_classify
  import sr_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int FREQ_W = 16,
  parameter int TOL    = 2,
  parameter int SS_LO  = 30,
  parameter int SS_HI  = 54,
  parameter int DS_LO  = 84,
  parameter int DS_HI  = 108,
  parameter int QS_LO  = 170,
  parameter int QS_HI  = 216
) (
  input  logic [CNT_W-1:0]   period_i,
  input  logic [FREQ_W-1:0]  mclk_khz_i,
  output logic [RCODE_W-1:0] code_o,
  output logic [1:0]         mode_o,
  output logic               supported_o
);
  logic [31:0] per, mk;
  logic [NUM_RATIOS:1] hit, ss, ds, qs;

  assign per = 32'(period_i);
  assign mk  = 32'(mclk_khz_i);

  for (genvar g = 1; g <= NUM_RATIOS; g++) begin : g_ratio
    localparam int unsigned RG  = ratio_of(g);
    localparam bit          SSM = (RG >= 256);
    localparam bit          DSM = (RG <= 512);
    localparam bit          QSM = (RG <= 256);
    assign hit[g] = (per + 32'(TOL) >= 32'(RG)) && (per <= 32'(RG) + 32'(TOL));
    // implied rate mclk/R within [lo,hi]  <=>  lo*R <= mclk <= hi*R
    assign ss[g] = SSM && hit[g] && (mk >= 32'(SS_LO) * 32'(RG)) && (mk <= 32'(SS_HI) * 32'(RG));
    assign ds[g] = DSM && hit[g] && (mk >= 32'(DS_LO) * 32'(RG)) && (mk <= 32'(DS_HI) * 32'(RG));
    assign qs[g] = QSM && hit[g] && (mk >= 32'(QS_LO) * 32'(RG)) && (mk <= 32'(QS_HI) * 32'(RG));
  end

  always_comb begin
    code_o = '0;
    for (int g = NUM_RATIOS; g >= 1; g--) begin
      if (hit[g]) code_o = RCODE_W'(g);
    end
  end

  always_comb begin
    supported_o = |{ss, ds, qs};
    if (|qs)      mode_o = MODE_QUAD;
    else if (|ds) mode_o = MODE_DOUBLE;
    else          mode_o = MODE_SINGLE;
  end
endmodule

// File: rtl/srate_mode_detect.sv
module srate_mode_detect
  import sr_pkg::*;
#(
  parameter int CNT_W     = 11,
  parameter int FREQ_W    = 16,
  parameter int TOL       = 2,
  parameter int LOCK_RUNS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ws_i,
  input  logic [FREQ_W-1:0] mclk_khz_i,
  input  logic              deemph_req_i,
  output logic [1:0]        mode_o,
  output logic [2:0]        ratio_o,
  output logic              locked_o,
  output logic              unsup_o,
  output logic              deemph_o
);
  localparam int RUN_W = $clog2(LOCK_RUNS + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUNS);

  logic               rise, meas_vld, timeout, supported;
  logic [CNT_W-1:0]   period;
  logic [RCODE_W-1:0] code;
  logic [1:0]         cls_mode;

  logic [1:0]         mode_q;
  logic [RCODE_W-1:0] ratio_q;
  logic               unsup_q;
  logic [RUN_W-1:0]   run_q;

  sr_ws_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ws_i  (ws_i),
    .rise_o(rise)
  );

  sr_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .meas_vld_o(meas_vld),
    .period_o  (period),
    .timeout_o (timeout)
  );

  sr_classify #(.CNT_W(CNT_W), .FREQ_W(FREQ_W), .TOL(TOL)) u_cls (
    .period_i   (period),
    .mclk_khz_i (mclk_khz_i),
    .code_o     (code),
    .mode_o     (cls_mode),
    .supported_o(supported)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SINGLE;
      ratio_q <= '0;
      unsup_q <= 1'b0;
      run_q   <= '0;
    end else if (meas_vld) begin
      ratio_q <= code;
      if (supported) begin
        mode_q  <= cls_mode;
        unsup_q <= 1'b0;
        if (run_q != '0 && code == ratio_q)
          run_q <= (run_q == RUN_FULL) ? RUN_FULL : run_q + 1'b1;
        else
          run_q <= RUN_W'(1);
      end else begin
        unsup_q <= 1'b1;  // mode held
        run_q   <= '0;
      end
    end else if (timeout) begin
      run_q <= '0;
    end
  end

  assign mode_o   = mode_q;
  assign ratio_o  = ratio_q;
  assign unsup_o  = unsup_q;
  assign locked_o = (run_q == RUN_FULL);
  assign deemph_o = deemph_req_i & locked_o & (mode_q == MODE_SINGLE);
endmodule

// File: rtl/srate_mode_detect_chk.sv
module srate_mode_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       deemph_req_i,
  input logic [1:0] mode_o,
  input logic [2:0] ratio_o,
  input logic       locked_o,
  input logic       unsup_o,
  input logic       deemph_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_values: assert (mode_o == 2'b00 && ratio_o == 3'd0 && !locked_o && !unsup_o && !deemph_o)
        else $error("R1 reset values");
    end
  end

  a_r2_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  a_r7_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unsup_o) |-> mode_o == $past(mode_o));

  a_r7_unsup_no_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> !locked_o);

  a_r8_lock_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> ratio_o != 3'd0);

  a_r9_lock_ratio_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> ratio_o == $past(ratio_o));

  a_r11_deemph_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deemph_o |-> (deemph_req_i && locked_o && mode_o == 2'b00));
endmodule

bind srate_mode_detect srate_mode_detect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .deemph_req_i(deemph_req_i),
  .mode_o      (mode_o),
  .ratio_o     (ratio_o),
  .locked_o    (locked_o),
  .unsup_o     (unsup_o),
  .deemph_o    (deemph_o)
);

// File: tb/sim_srate_mode_detect.sv
`timescale 1ns/1ps
module sim_srate_mode_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ws;
  logic [15:0] mclk_khz;
  logic        deemph_req;
  logic [1:0]  mode;
  logic [2:0]  ratio;
  logic        locked, unsup, deemph;

  int checks = 0;
  int errors = 0;
  localparam int MAXC = 2047;

  always #5 clk = ~clk;

  srate_mode_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .ws_i(ws), .mclk_khz_i(mclk_khz),
    .deemph_req_i(deemph_req), .mode_o(mode), .ratio_o(ratio),
    .locked_o(locked), .unsup_o(unsup), .deemph_o(deemph)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- reference model ----
  int w1, w2, w3, mcnt, m_mode, m_ratio, m_run;
  bit armed, m_unsup;

  function automatic void classify(input int per, input int mk,
                                   output int code, output int md, output bit ok);
    int rt[7] = '{128, 192, 256, 384, 512, 768, 1024};
    int r;
    code = 0; md = 0; ok = 0;
    for (int i = 6; i >= 0; i--)
      if (per >= rt[i] - 2 && per <= rt[i] + 2) code = i + 1;
    if (code == 0) return;
    r = rt[code - 1];
    if (r >= 256 && mk >= 30 * r && mk <= 54 * r) begin md = 0; ok = 1; end
    if (r <= 512 && mk >= 84 * r && mk <= 108 * r) begin md = 1; ok = 1; end
    if (r <= 256 && mk >= 170 * r && mk <= 216 * r) begin md = 2; ok = 1; end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1 = 0; w2 = 0; w3 = 0; mcnt = 0; armed = 0;
      m_mode = 0; m_ratio = 0; m_run = 0; m_unsup = 0;
    end else begin
      bit pulse;
      pulse = (w2 == 1) && (w3 == 0);
      if (pulse) begin
        if (armed) begin
          int c, md; bit ok;
          classify(mcnt + 1, int'(mclk_khz), c, md, ok);
          if (ok) begin
            m_run = (m_run != 0 && c == m_ratio) ? ((m_run < 3) ? m_run + 1 : 3) : 1;
            m_mode = md; m_unsup = 0;
          end else begin
            m_run = 0; m_unsup = 1;
          end
          m_ratio = c;
        end
        mcnt = 0; armed = 1;
      end else begin
        if (mcnt == MAXC - 1) begin armed = 0; m_run = 0; end
        if (mcnt < MAXC) mcnt++;
      end
      w3 = w2; w2 = w1; w1 = int'(ws);
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(int'(mode) == m_mode, "R3 mode vs model", int'(mode), m_mode);
      chk(int'(ratio) == m_ratio, "R2 ratio vs model", int'(ratio), m_ratio);
      chk(locked == (m_run == 3), "R8 locked vs model", int'(locked), int'(m_run == 3));
      chk(unsup == m_unsup, "R7 unsup vs model", int'(unsup), int'(m_unsup));
      chk(deemph == (deemph_req && m_run == 3 && m_mode == 0), "R11 deemph vs model",
          int'(deemph), int'(deemph_req && m_run == 3 && m_mode == 0));
    end
  end

  task automatic periods(input int p, input int n);
    for (int k = 0; k < n; k++)
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        ws = (c < p / 2);
      end
  endtask

  task automatic expect_state(input string tag, input int e_mode, input int e_ratio,
                              input int e_lock, input int e_unsup);
    chk(int'(mode) == e_mode, {tag, " mode"}, int'(mode), e_mode);
    chk(int'(ratio) == e_ratio, {tag, " ratio"}, int'(ratio), e_ratio);
    chk(int'(locked) == e_lock, {tag, " locked"}, int'(locked), e_lock);
    chk(int'(unsup) == e_unsup, {tag, " unsup"}, int'(unsup), e_unsup);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; ws = 1'b0; mclk_khz = 16'd12288; deemph_req = 1'b0;
    repeat (4) @(negedge clk);
    expect_state("R1 reset", 0, 0, 0, 0);
    chk(deemph == 1'b0, "R1 reset deemph", int'(deemph), 0);
    @(negedge clk) rst_n = 1'b1;

    // single speed, ratio 256 at 12288 kHz (48 kHz)
    periods(256, 4);
    expect_state("R3 R8 single 256", 0, 3, 1, 0);
    deemph_req = 1'b1;
    @(negedge clk);
    chk(deemph == 1'b1, "R11 deemph in single", int'(deemph), 1);

    // same ratio, double the clock: double speed
    mclk_khz = 16'd24576;
    periods(256, 4);
    expect_state("R4 R6 double 256", 1, 3, 1, 0);
    chk(deemph == 1'b0, "R11 deemph off in double", int'(deemph), 0);

    // quad speed, ratio 128 at 24576 kHz (192 kHz)
    periods(128, 4);
    expect_state("R5 quad 128", 2, 1, 1, 0);

    // 1024 at 12288 kHz -> 12 kHz, no mode; first measurement (128) gives double
    mclk_khz = 16'd12288;
    periods(1024, 4);
    expect_state("R7 unsupported rate holds mode", 1, 7, 0, 1);

    // ratio not in table
    periods(300, 3);
    expect_state("R2 R7 ratio off table", 1, 0, 0, 1);

    // single at 512 / 24576 kHz, then tolerance and deviation
    mclk_khz = 16'd24576;
    periods(512, 4);
    expect_state("R3 R8 single 512", 0, 5, 1, 0);
    chk(deemph == 1'b1, "R11 deemph single locked", int'(deemph), 1);
    periods(513, 1);
    periods(515, 1);
    expect_state("R9 within tolerance keeps lock", 0, 5, 1, 0);
    periods(512, 1);
    expect_state("R9 deviation drops lock", 0, 0, 0, 1);
    chk(deemph == 1'b0, "R11 deemph off unlocked", int'(deemph), 0);

    // relock then let word-select stall
    periods(512, 3);
    chk(locked == 1'b1, "R8 relock", int'(locked), 1);
    ws = 1'b0;
    repeat (2100) @(negedge clk);
    expect_state("R10 timeout clears lock", 0, 5, 0, 0);

    // first edge after timeout is not measured
    periods(256, 1);
    expect_state("R12 first edge ignored", 0, 5, 0, 0);
    periods(256, 4);
    expect_state("R12 R6 measuring resumes", 1, 3, 1, 0);

    deemph_req = 1'b0;
    repeat (5) @(negedge clk);
    summary();
  end
endmodule